// File: doc/BRIEF.md
# SPI Slave Frame Port with BUSY Handshake

This block is the host-facing serial port of a peripheral. A host controller talks to it over a four-wire SPI link in mode 0 (SCK idles low, data sampled on the rising edge and changed on the falling edge). The link is half-duplex, and one extra output, BUSY, provides flow control. Each select-low period carries exactly one atomic frame. That frame is either a command sent by the host or a readout of the response buffer. Frames are never chained across select periods.

A command frame starts with a command code byte and a length byte, followed by that many payload bytes. The port raises BUSY only after a complete and well-formed frame has ended. It then holds BUSY for a fixed processing time while a stub handler executes the command. A read command prepares the response buffer, and BUSY drops once that data is ready. The host then reads all buffer bytes in its next select period. A bad length raises a sticky interrupt and error flag. A truncated frame raises a sticky abort flag. Only a clear command resets these flags. All pins are sampled into the system clock through two-flop synchronizers, so the system clock must run at least four times faster than SCK.

Top module: `spi_busy_slave`

## Requirements
- R1: Bits on MOSI are taken on rising SCK edges while NSS is low, most significant bit first.
- R2: During a read frame, MISO presents the response buffer starting with byte 0, most significant bit first. It advances one bit per falling SCK edge.
- R3: While NSS is high, miso_oe is 0 and MISO is not driven by data: it floats, or reads 1 when pullup_en is 1. While NSS is low, miso_oe is 1.
- R4: BUSY goes high within 6 system cycles after NSS rises at the end of a complete command frame. It stays high for BUSY_CYCLES cycles, then drops. Bits clocked in while BUSY is high are ignored.
- R5: A read command (code 0x02) leaves the BUFFER contents in the response register when BUSY drops. The next select period reads out all BUF_BYTES bytes and ends the read phase.
- R6: A length byte greater than BUF_BYTES (4) is a parameter error: irq and err_flag are set, and the command is not executed.
- R7: If NSS rises mid-byte, or before 2 + length bytes have arrived (or after too many bytes), the frame is dropped. BUSY stays low, abort_flag is set, and the buffer is unchanged.
- R8: irq, err_flag and abort_flag stay set across later frames until a clear command (code 0x03, length 0) clears all three.
- R9: Byte 0 of a frame is the command code and byte 1 is the length. A write command (code 0x01) copies its payload into buffer bytes 0..length-1 and leaves the other bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from host |
| mosi | input | 1 | Serial data from host |
| nss | input | 1 | Active-low frame select |
| pullup_en | input | 1 | Pull MISO high while NSS is high |
| miso | output | 1 | Serial data to host, high impedance when deselected |
| miso_oe | output | 1 | High while MISO is actively driven |
| busy | output | 1 | Frame being processed; host must wait |
| irq | output | 1 | Interrupt request on parameter error |
| err_flag | output | 1 | Sticky general-error status |
| abort_flag | output | 1 | Sticky truncated-frame status |

## Verification
The bench writes payloads of lengths 0 through 4 plus one illegal length. It reads the buffer back after each one, so a design that wrote past the declared length, or read out bytes in the wrong order, returns a wrong word. The bench cuts a frame mid-byte and also one byte short. A design that accepted partial frames would raise BUSY or corrupt the buffer. Flags are checked to survive unrelated frames and to fall only on the clear command. MISO drive is checked on both sides of the select edge, including the pull-up case.

// File: rtl/spi_busy_slave.sv
module spi_busy_slave #(
  parameter int BUF_BYTES   = 4,
  parameter int BUSY_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic mosi,
  input  logic nss,
  input  logic pullup_en,
  output logic miso,
  output logic miso_oe,
  output logic busy,
  output logic irq,
  output logic err_flag,
  output logic abort_flag
);
  localparam int TXW = 8 * BUF_BYTES;
  localparam int TW  = $clog2(BUSY_CYCLES + 1);
  localparam logic [7:0] CMD_WR  = 8'h01;
  localparam logic [7:0] CMD_RD  = 8'h02;
  localparam logic [7:0] CMD_CLR = 8'h03;

  logic [2:0] sck_q, nss_q;
  logic [1:0] mosi_q;
  logic [6:0] sh;
  logic [2:0] bitcnt;
  logic [3:0] bytecnt;
  logic [7:0] cmd, len;
  logic [7:0] pay [BUF_BYTES];
  logic [7:0] bufr [BUF_BYTES];
  logic [TXW-1:0] tx;
  logic rd_mode, rd_req;
  logic [TW-1:0] tmr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q  <= '0;
      nss_q  <= '1;
      mosi_q <= '0;
    end else begin
      sck_q  <= {sck_q[1:0], sck};
      nss_q  <= {nss_q[1:0], nss};
      mosi_q <= {mosi_q[0], mosi};
    end

  wire sck_rise  = sck_q[1] & ~sck_q[2];
  wire sck_fall  = ~sck_q[1] & sck_q[2];
  wire nss_start = ~nss_q[1] & nss_q[2];
  wire nss_end   = nss_q[1] & ~nss_q[2];
  wire sel       = ~nss_q[1];
  wire [7:0] nb  = {sh, mosi_q[1]};
  wire len_bad   = len > 8'(BUF_BYTES);
  wire [7:0] need = len + 8'd2;
  wire frame_ok  = (bitcnt == 3'd0) && (bytecnt >= 4'd2) && (len_bad || {4'd0, bytecnt} == need);
  wire commit    = nss_end && !busy && !rd_mode && frame_ok;
  wire do_clear  = commit && !len_bad && cmd == CMD_CLR;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh <= '0; bitcnt <= '0; bytecnt <= '0; cmd <= '0; len <= '0;
      for (int i = 0; i < BUF_BYTES; i++) pay[i] <= '0;
    end else if (nss_start) begin
      bitcnt  <= '0;
      bytecnt <= '0;
    end else if (sel && sck_rise && !busy) begin
      sh     <= nb[6:0];
      bitcnt <= bitcnt + 3'd1;
      if (bitcnt == 3'd7) begin
        if (bytecnt != 4'hF) bytecnt <= bytecnt + 4'd1;
        if (!rd_mode) begin
          if (bytecnt == 4'd0) cmd <= nb;
          if (bytecnt == 4'd1) len <= nb;
          for (int i = 0; i < BUF_BYTES; i++)
            if (int'(bytecnt) == i + 2) pay[i] <= nb;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; tmr <= '0; rd_req <= 1'b0; rd_mode <= 1'b0;
      irq <= 1'b0; err_flag <= 1'b0; abort_flag <= 1'b0; tx <= '0;
      for (int i = 0; i < BUF_BYTES; i++) bufr[i] <= '0;
    end else begin
      if (busy) begin
        tmr <= tmr - TW'(1);
        if (tmr == TW'(1)) begin
          busy    <= 1'b0;
          rd_mode <= rd_req;
        end
      end
      if (nss_end && !busy) begin
        if (rd_mode) begin
          rd_mode <= 1'b0;
          if (bitcnt != 3'd0 || int'(bytecnt) != BUF_BYTES) abort_flag <= 1'b1;
        end else if (frame_ok) begin
          busy   <= 1'b1;
          tmr    <= TW'(BUSY_CYCLES);
          rd_req <= !len_bad && cmd == CMD_RD;
          if (len_bad) begin
            irq      <= 1'b1;
            err_flag <= 1'b1;
          end else if (cmd == CMD_WR) begin
            for (int i = 0; i < BUF_BYTES; i++)
              if (8'(i) < len) bufr[i] <= pay[i];
          end else if (cmd == CMD_RD) begin
            for (int i = 0; i < BUF_BYTES; i++) tx[TXW-1-8*i -: 8] <= bufr[i];
          end else if (cmd == CMD_CLR) begin
            irq <= 1'b0; err_flag <= 1'b0; abort_flag <= 1'b0;
          end
        end else begin
          abort_flag <= 1'b1;
        end
      end
      if (sel && sck_fall && rd_mode) tx <= {tx[TXW-2:0], 1'b0};
    end

  assign miso_oe = ~nss;
  assign miso    = ~nss ? (rd_mode ? tx[TXW-1] : 1'b0) : (pullup_en ? 1'b1 : 1'bz);

  // R4
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(nss_end));
  // R4
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) (busy && !nss_start) |=> $stable(bytecnt));
  // R7
  abort_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(abort_flag) |-> !busy);
  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(err_flag) |-> $past(do_clear));
  // R5
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_mode |-> !busy);
endmodule

// File: tb/sim_spi_busy_slave.sv
module sim_spi_busy_slave;
  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, mosi = 1'b0, nss = 1'b1, pullup_en = 1'b0;
  logic miso, miso_oe, busy, irq, err_flag, abort_flag;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spi_busy_slave u0 (.clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .nss(nss),
    .pullup_en(pullup_en), .miso(miso), .miso_oe(miso_oe), .busy(busy), .irq(irq),
    .err_flag(err_flag), .abort_flag(abort_flag));

  localparam logic [39:0] VEC [6] = '{
    {8'd4, 32'hA1B2C3D4}, {8'd2, 32'h5E6F0000}, {8'd0, 32'h77777777},
    {8'd1, 32'h99000000}, {8'd3, 32'h01020304}, {8'd7, 32'hDEADBEEF}};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xbyte(input logic [7:0] d, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      mosi = d[i];
      repeat (4) @(negedge clk);
      r[i] = miso;
      sck = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic frame(input logic [47:0] b, input int n);
    logic [7:0] r;
    nss = 1'b0;
    repeat (4) @(negedge clk);
    for (int k = 0; k < n; k++) xbyte(b[47-8*k -: 8], r);
    repeat (4) @(negedge clk);
    nss = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_idle();
    repeat (6) @(negedge clk);
    for (int k = 0; k < 200 && busy; k++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic rd(output logic [31:0] v);
    logic [7:0] r;
    frame({8'h02, 8'h00, 32'h0}, 2);
    wait_idle();
    nss = 1'b0;
    repeat (4) @(negedge clk);
    chk(miso_oe == 1'b1, "R3", 32'(miso_oe), 32'h1);
    for (int k = 0; k < 4; k++) begin
      xbyte(8'h00, r);
      v[31-8*k -: 8] = r;
    end
    repeat (4) @(negedge clk);
    nss = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] model, got;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 0 && irq == 0 && err_flag == 0 && abort_flag == 0, "R4 reset", {busy, irq, err_flag, abort_flag}, 0);
    chk(miso_oe == 1'b0, "R3", 32'(miso_oe), 0);
    pullup_en = 1'b1;
    #1;
    chk(miso === 1'b1, "R3 pullup", 32'(miso), 1);
    pullup_en = 1'b0;

    model = 32'h0;
    for (int v = 0; v < 6; v++) begin
      logic [7:0] l;
      l = VEC[v][39:32];
      frame({8'h01, l, VEC[v][31:0]}, (l > 4) ? 2 : 2 + int'(l));
      repeat (6) @(negedge clk);
      chk(busy == 1'b1, "R4 busy after frame", 32'(busy), 1);
      wait_idle();
      chk(busy == 1'b0, "R4 busy drops", 32'(busy), 0);
      if (l <= 4)
        for (int i = 0; i < 4; i++)
          if (i < int'(l)) model[31-8*i -: 8] = VEC[v][31-8*i -: 8];
      chk(err_flag == (l > 4) && irq == (l > 4), "R6", {irq, err_flag}, (l > 4) ? 3 : 0);
      rd(got);
      chk(got == model, "R9 R1 R2 R5 readback", got, model);
    end
    chk(model == 32'h010203D4, "R9 model", model, 32'h010203D4);

    frame({8'h01, 8'h01, 32'h0}, 2);
    wait_idle();
    chk(irq == 1'b1 && err_flag == 1'b1, "R8 sticky", {irq, err_flag}, 3);
    frame({8'h03, 8'h00, 32'h0}, 2);
    wait_idle();
    chk(irq == 0 && err_flag == 0 && abort_flag == 0, "R8 clear", {irq, err_flag, abort_flag}, 0);

    nss = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 7; i >= 4; i--) begin
      mosi = 1'b1; repeat (4) @(negedge clk); sck = 1'b1; repeat (4) @(negedge clk); sck = 1'b0;
    end
    repeat (4) @(negedge clk);
    nss = 1'b1;
    repeat (8) @(negedge clk);
    chk(busy == 1'b0, "R7 mid-byte no busy", 32'(busy), 0);
    chk(abort_flag == 1'b1, "R7 mid-byte abort", 32'(abort_flag), 1);

    frame({8'h03, 8'h00, 32'h0}, 2);
    wait_idle();
    frame({8'h01, 8'h03, 32'hFFFF0000}, 4);
    repeat (6) @(negedge clk);
    chk(busy == 1'b0, "R7 short no busy", 32'(busy), 0);
    chk(abort_flag == 1'b1, "R7 short abort", 32'(abort_flag), 1);
    rd(got);
    chk(got == model, "R7 buffer unchanged", got, model);
    chk(abort_flag == 1'b1, "R8 abort sticky", 32'(abort_flag), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule